// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps every row of an asynchronous DRAM alive by issuing one refresh cycle per refresh interval. The interval is the retention period divided by the number of rows. A free-running timer derives it from the clock frequency and the retention period, and a long-retention option stretches the retention period eightfold. Each expiry of the interval adds one pending refresh to a small saturating backlog. While any refresh is pending and the sequencer is idle, the block raises a request toward the memory access controller. Page bursts from other masters can therefore delay refresh for several intervals without losing it.

When the controller grants the request, the block takes over the row strobe, both column strobes, the write enable and the address lines for one refresh cycle. Two refresh styles can be chosen, and the choice is sampled at the grant. In the addressed style, the block drives its own row counter onto the address lines with the row strobe low and both column strobes high, then steps the counter. In the counter-driven style, both column strobes fall ahead of the row strobe, so the device chooses the row itself and the address lines are left undriven. Each cycle ends with a fixed precharge time, and a one-cycle done pulse marks its end.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, `ras_n`, `cas_l_n`, `cas_h_n` and `we_n` are 1, `addr_oe` is 0 and `ref_req` is 0.
- R2: `ref_req` first goes high INTERVAL clock cycles after reset is released. INTERVAL = RETENTION_US × CLK_MHZ × (8 if LONG_RET = 1, else 1) / ROWS, where ROWS is a power of two.
- R3: Once high, `ref_req` stays high until a cycle in which `ref_gnt` is also high. A `ref_gnt` given while `ref_req` is low starts no refresh and leaves every strobe high.
- R4: Each interval adds one pending refresh, up to BACKLOG_MAX pending; further intervals are dropped while the backlog is full. With `ref_gnt` held high, the pending refreshes are performed back to back and then `ref_req` falls.
- R5: In the addressed style (`cbr_mode` = 0 at the grant), while `ras_n` is low, `addr` carries the row counter, `addr_oe` is 1 and both CAS strobes are 1.
- R6: The row counter starts at 0 and steps by one after each addressed refresh, wrapping from ROWS−1 to 0. Counter-driven refreshes leave it unchanged.
- R7: In the counter-driven style (`cbr_mode` = 1 at the grant), both CAS strobes are low for exactly TCSR cycles with `ras_n` high before `ras_n` falls, and `addr_oe` stays 0.
- R8: Every refresh holds `ras_n` low for exactly TRAS cycles, then high for TRP cycles, and `ref_done` is high for one cycle, in the last of those TRP cycles.
- R9: `we_n` is 1 at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cbr_mode | input | 1 | Refresh style, sampled at the grant: 0 = addressed, 1 = counter-driven |
| ref_gnt | input | 1 | Grant from the access controller |
| ref_req | output | 1 | Refresh request |
| ref_done | output | 1 | One-cycle pulse at the end of a refresh cycle |
| ras_n | output | 1 | Row strobe, active low |
| cas_l_n | output | 1 | Lower-byte column strobe, active low |
| cas_h_n | output | 1 | Upper-byte column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high) |
| addr | output | ROW_W | Row address for addressed refresh |
| addr_oe | output | 1 | High while `addr` must drive the address lines |

## Verification
The assertions assume that the controller leaves the pins to this block from the grant until `ref_done`. They also assume that `cbr_mode` only changes while the block is idle with its request up or low, because the style seen at a row-strobe fall is taken to be the one latched at the grant. The bench keeps to these assumptions. It changes `cbr_mode` only at a falling clock edge where `ref_req` is high and, in the same cycle, drops `ref_gnt`, so no cycle begins in the middle of the switch. It also raises the grant only at chosen points relative to the interval ticks, so that the size of the backlog is known exactly when it is drained.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CSR  = 2'd1,
    ST_RAS  = 2'd2,
    ST_PRE  = 2'd3
  } ref_state_e;

  // Cycles between refresh ticks: retention time spread over all rows.
  function automatic int interval_cycles(input int ret_us, input int mhz,
                                         input int long_ret, input int rows);
    int scale;
    scale = (long_ret != 0) ? 8 : 1;
    return (ret_us * mhz * scale) / rows;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int INTERVAL = 1562,
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dram_ref_backlog.sv
module dram_ref_backlog #(
  parameter int BACKLOG_MAX = 4,
  localparam int LW = $clog2(BACKLOG_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          take,
  output logic          pending,
  output logic [LW-1:0] level
);
  localparam logic [LW-1:0] FULL = LW'(BACKLOG_MAX);

  assign pending = (level != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
    end else begin
      case ({tick, take})
        2'b10:   if (level != FULL) level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/dram_ref_rowctr.sv
module dram_ref_rowctr #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [ROW_W-1:0] row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   row <= '0;
    else if (adv) row <= row + 1'b1;
  end
endmodule

// File: rtl/dram_ref_seq.sv
module dram_ref_seq
  import dram_ref_pkg::*;
#(
  parameter int TCSR = 2,
  parameter int TRAS = 6,
  parameter int TRP  = 4,
  localparam int PW  = $clog2(max3(TCSR, TRAS, TRP) + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic gnt,
  input  logic cbr_mode,
  output logic req,
  output logic take,
  output logic row_adv,
  output logic done,
  output logic cbr_q,
  output logic ras_n,
  output logic cas_n,
  output logic addr_oe
);
  ref_state_e    state;
  logic [PW-1:0] ph;

  assign req     = pending && (state == ST_IDLE);
  assign take    = req && gnt;
  assign row_adv = (state == ST_RAS) && (ph == '0) && !cbr_q;
  assign done    = (state == ST_PRE) && (ph == '0);
  assign ras_n   = (state != ST_RAS);
  assign cas_n   = !(cbr_q && ((state == ST_CSR) || (state == ST_RAS)));
  assign addr_oe = !cbr_q && (state == ST_RAS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ph    <= '0;
      cbr_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (take) begin
          cbr_q <= cbr_mode;
          if (cbr_mode) begin
            state <= ST_CSR;
            ph    <= PW'(TCSR - 1);
          end else begin
            state <= ST_RAS;
            ph    <= PW'(TRAS - 1);
          end
        end
        ST_CSR: if (ph == '0) begin
          state <= ST_RAS;
          ph    <= PW'(TRAS - 1);
        end else begin
          ph <= ph - 1'b1;
        end
        ST_RAS: if (ph == '0) begin
          state <= ST_PRE;
          ph    <= PW'(TRP - 1);
        end else begin
          ph <= ph - 1'b1;
        end
        default: if (ph == '0) begin
          state <= ST_IDLE;
        end else begin
          ph <= ph - 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int CLK_MHZ      = 100,
  parameter int RETENTION_US = 16000,
  parameter int LONG_RET     = 0,
  parameter int ROWS         = 1024,
  parameter int TCSR         = 2,
  parameter int TRAS         = 6,
  parameter int TRP          = 4,
  parameter int BACKLOG_MAX  = 4,
  localparam int ROW_W       = $clog2(ROWS),
  localparam int LW          = $clog2(BACKLOG_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cbr_mode,
  input  logic             ref_gnt,
  output logic             ref_req,
  output logic             ref_done,
  output logic             ras_n,
  output logic             cas_l_n,
  output logic             cas_h_n,
  output logic             we_n,
  output logic [ROW_W-1:0] addr,
  output logic             addr_oe
);
  localparam int INTERVAL = interval_cycles(RETENTION_US, CLK_MHZ, LONG_RET, ROWS);

  // Named internal events, visible to the bound checker.
  logic             tick_w;
  logic             take_w;
  logic             pend_w;
  logic             adv_w;
  logic             cbr_w;
  logic             cas_w;
  logic [LW-1:0]    level_w;
  logic [ROW_W-1:0] row_w;

  dram_ref_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick_w)
  );

  dram_ref_backlog #(.BACKLOG_MAX(BACKLOG_MAX)) u_backlog (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .take(take_w),
    .pending(pend_w), .level(level_w)
  );

  dram_ref_rowctr #(.ROW_W(ROW_W)) u_row (
    .clk(clk), .rst_n(rst_n), .adv(adv_w), .row(row_w)
  );

  dram_ref_seq #(.TCSR(TCSR), .TRAS(TRAS), .TRP(TRP)) u_seq (
    .clk(clk), .rst_n(rst_n), .pending(pend_w), .gnt(ref_gnt),
    .cbr_mode(cbr_mode), .req(ref_req), .take(take_w), .row_adv(adv_w),
    .done(ref_done), .cbr_q(cbr_w), .ras_n(ras_n), .cas_n(cas_w),
    .addr_oe(addr_oe)
  );

  assign cas_l_n = cas_w;
  assign cas_h_n = cas_w;
  assign we_n    = 1'b1;
  assign addr    = row_w;
endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk #(
  parameter int ROW_W       = 10,
  parameter int LW          = 3,
  parameter int BACKLOG_MAX = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_gnt,
  input logic             ref_req,
  input logic             ref_done,
  input logic             ras_n,
  input logic             cas_l_n,
  input logic             cas_h_n,
  input logic             we_n,
  input logic             addr_oe,
  input logic             cbr_q,
  input logic [LW-1:0]    level,
  input logic [ROW_W-1:0] row
);
  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req && !ref_gnt |=> ref_req);

  p_backlog_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(BACKLOG_MAX));

  p_addr_cas_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n && addr_oe |-> cas_l_n && cas_h_n);

  p_row_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) && !cbr_q |-> row == ($past(row) + 1'b1));

  p_row_hold_cbr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) && cbr_q |-> $stable(row));

  p_cbr_setup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) && cbr_q |-> $past(!cas_l_n && !cas_h_n) && !addr_oe);

  p_done_precharge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |-> ras_n && cas_l_n && cas_h_n);

  p_we_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we_n);
endmodule

bind dram_refresh_sched dram_refresh_chk #(
  .ROW_W(ROW_W), .LW(LW), .BACKLOG_MAX(BACKLOG_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
  .ref_done(ref_done), .ras_n(ras_n), .cas_l_n(cas_l_n), .cas_h_n(cas_h_n),
  .we_n(we_n), .addr_oe(addr_oe), .cbr_q(cbr_w), .level(level_w), .row(row_w)
);

// File: tb/dram_refresh_sched_tb.sv
module dram_refresh_sched_tb;
  localparam int MHZ   = 1;
  localparam int RETUS = 640;
  localparam int ROWS  = 16;
  localparam int TCSR  = 2;
  localparam int TRAS  = 4;
  localparam int TRP   = 3;
  localparam int BMAX  = 4;
  localparam int IVL   = RETUS * MHZ / ROWS;  // 40 cycles
  localparam int RW    = $clog2(ROWS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cbr_mode = 1'b0;
  logic ref_gnt = 1'b0;
  logic ref_req, ref_done, ras_n, cas_l_n, cas_h_n, we_n, addr_oe;
  logic [RW-1:0] addr;
  logic req_l, done_l, ras_l, casl_l, cash_l, we_l, oe_l;
  logic [RW-1:0] addr_l;

  int total = 0;
  int bad = 0;
  int ecnt = 0;
  int n_done = 0;
  int n_falls = 0;
  int exp_row = 0;
  int cas_run = 0;
  int ras_run = 0;
  int pre_run = 0;
  bit in_pre = 0;
  bit prev_ras = 1;
  bit finished = 0;

  always #5 clk = ~clk;

  dram_refresh_sched #(
    .CLK_MHZ(MHZ), .RETENTION_US(RETUS), .LONG_RET(0), .ROWS(ROWS),
    .TCSR(TCSR), .TRAS(TRAS), .TRP(TRP), .BACKLOG_MAX(BMAX)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cbr_mode(cbr_mode), .ref_gnt(ref_gnt),
    .ref_req(ref_req), .ref_done(ref_done), .ras_n(ras_n),
    .cas_l_n(cas_l_n), .cas_h_n(cas_h_n), .we_n(we_n), .addr(addr),
    .addr_oe(addr_oe)
  );

  dram_refresh_sched #(
    .CLK_MHZ(MHZ), .RETENTION_US(RETUS), .LONG_RET(1), .ROWS(ROWS),
    .TCSR(TCSR), .TRAS(TRAS), .TRP(TRP), .BACKLOG_MAX(BMAX)
  ) u_dut_long (
    .clk(clk), .rst_n(rst_n), .cbr_mode(1'b0), .ref_gnt(1'b0),
    .ref_req(req_l), .ref_done(done_l), .ras_n(ras_l),
    .cas_l_n(casl_l), .cas_h_n(cash_l), .we_n(we_l), .addr(addr_l),
    .addr_oe(oe_l)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) ecnt <= ecnt + 1;

  // Per-cycle pin monitor for the main instance.
  always @(negedge clk) begin
    if (rst_n) begin
      if (ras_n && !cas_l_n && !cas_h_n) cas_run++;
      else if (cas_l_n) cas_run = 0;
      if (!ras_n) begin
        if (prev_ras) begin
          n_falls++;
          ras_run = 0;
          if (cbr_mode) begin
            chk(cas_run == TCSR, "R7 cas lead", cas_run, TCSR);
            chk(!addr_oe, "R7 addr_oe", addr_oe, 0);
          end else begin
            chk(int'(addr) == exp_row, "R6 row addr", addr, exp_row);
            chk(addr_oe && cas_l_n && cas_h_n, "R5 pins", {addr_oe, cas_l_n, cas_h_n}, 7);
            exp_row = (exp_row + 1) % ROWS;
          end
        end
        ras_run++;
      end else if (!prev_ras) begin
        chk(ras_run == TRAS, "R8 ras low", ras_run, TRAS);
        in_pre = 1;
        pre_run = 1;
      end else if (in_pre) begin
        pre_run++;
      end
      if (ref_done) begin
        chk(in_pre && pre_run == TRP, "R8 precharge", pre_run, TRP);
        chk(we_n, "R9 we_n", we_n, 1);
        n_done++;
        in_pre = 0;
      end
      prev_ras = ras_n;
    end
  end

  task automatic wait_ecnt(input int target);
    while (ecnt < target) @(negedge clk);
  endtask

  task automatic wait_dones(input int n);
    int base;
    base = n_done;
    while (n_done < base + n) @(negedge clk);
  endtask

  // Switch style at an idle cycle with request up, so no cycle is split.
  task automatic switch_mode(input bit m);
    @(negedge clk);
    while (!ref_req) @(negedge clk);
    ref_gnt = 1'b0;
    cbr_mode = m;
    @(negedge clk);
    ref_gnt = 1'b1;
  endtask

  // Long-retention instance: first request after 8 intervals (R2).
  initial begin
    @(posedge rst_n);
    @(negedge clk);
    while (!req_l) @(negedge clk);
    chk(ecnt == 8 * IVL, "R2 long interval", ecnt, 8 * IVL);
  end

  initial begin
    int base;
    int first_req;
    #1;
    chk(ras_n && cas_l_n && cas_h_n && we_n && !addr_oe && !ref_req,
        "R1 reset pins", {ras_n, cas_l_n, cas_h_n, we_n, addr_oe, ref_req}, 6'b111100);
    repeat (3) @(negedge clk);
    chk(ras_n && !ref_req && !addr_oe, "R1 held reset", {ras_n, ref_req}, 2);
    rst_n = 1'b1;
    // R3: grant without request is ignored.
    ref_gnt = 1'b1;
    wait_ecnt(IVL - 2);
    ref_gnt = 1'b0;
    chk(n_falls == 0 && ras_n && cas_l_n, "R3 gnt ignored", n_falls, 0);
    // R2: first request timing.
    while (!ref_req) @(negedge clk);
    first_req = ecnt;
    chk(first_req == IVL, "R2 interval", first_req, IVL);
    // R3: request held without grant; R4 backlog saturates.
    wait_ecnt(6 * IVL + 1);
    chk(ref_req && n_falls == 0, "R3 req held", ref_req, 1);
    base = n_done;
    ref_gnt = 1'b1;
    wait_ecnt(6 * IVL + 37);
    chk(n_done - base == BMAX, "R4 saturated backlog", n_done - base, BMAX);
    chk(!ref_req, "R4 drained", ref_req, 0);
    ref_gnt = 1'b0;
    // R4: three intervals give three pending refreshes.
    wait_ecnt(9 * IVL + 1);
    base = n_done;
    ref_gnt = 1'b1;
    wait_ecnt(9 * IVL + 37);
    chk(n_done - base == 3, "R4 partial backlog", n_done - base, 3);
    chk(!ref_req, "R4 drained again", ref_req, 0);
    // R5/R6: addressed sweep through the wrap.
    wait_dones(ROWS + 4);
    chk(exp_row == (BMAX + 3 + ROWS + 4) % ROWS, "R6 wrap count", exp_row,
        (BMAX + 3 + ROWS + 4) % ROWS);
    // R7: counter-driven cycles, row counter untouched.
    switch_mode(1'b1);
    wait_dones(5);
    switch_mode(1'b0);
    wait_dones(3);
    chk(n_falls == BMAX + 3 + ROWS + 4 + 5 + 3, "R8 cycle count", n_falls,
        BMAX + 3 + ROWS + 4 + 5 + 3);
    ref_gnt = 1'b0;
    repeat (5) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20000 * 10);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", ecnt, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule